// File: doc/BRIEF.md
# Nested Multi-Level Interrupt Arbiter

This block is the interrupt decision point beside a small CPU core. It holds one pending bit per programmable source and takes a separate power-fail input. Each programmable source has its own enable and a 2-bit priority, and a global enable gates all of them. The power-fail request sits at a fixed top level and does not answer to the global enable. At each instruction boundary the CPU raises a strobe. The block then picks the best eligible request and returns a one-cycle acknowledge carrying the source index and its level.

A 5-bit in-service mask records which levels have service routines open, so routines can nest. A grant sets the bit of the granted level. A return-from-interrupt pulse clears the highest set bit. The current level is the top set bit, and only a request above it can be granted. One register write port loads the pending bits, the enables or the priorities. A boundary that closes an instruction which wrote the enables or priorities is not evaluated, so the new settings take effect at the boundary after it.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset no acknowledge is issued, the in-service mask is 0, and every programmable source has priority 0.
- R2: The power-fail request is granted at level 4 with vector index NUM_SRC (6 by default) while `pf_in` is high and its enable (enable word bit NUM_SRC+1) is set. The global enable has no effect on it. Clearing its own enable stops it.
- R3: A request is granted only if its level is strictly above every level set in the in-service mask. Requests at an equal or lower level stay pending.
- R4: Among eligible requests at the same level, the lowest source index wins.
- R5: Writing 1 to a pending bit (select 0, bit i = source i) raises a request that is granted just like a hardware-raised one.
- R6: A pending bit cleared by software before a grant yields no grant. Clearing it after the grant leaves the in-service mask unchanged.
- R7: When hardware sets a pending bit in the same cycle that software writes the pending register, the bit ends up set.
- R8: A boundary strobe is ignored if an enable write (select 1) or priority write (select 2) happens in that cycle or since the previous strobe. The next strobe uses the new values.
- R9: Sources flagged in AUTO_CLR_MASK (0 to 3 by default) have their pending bit cleared on grant. The others (4 and 5) keep it until software clears it.
- R10: A return pulse clears only the highest set bit of the in-service mask.
- R11: A grant shows `ack` high for exactly one cycle, with `ack_vec` = source index and `ack_lvl` = level (priority field value, or 4 for power fail), one cycle after the strobe.
- R12: Sources in EDGE_MASK (0 to 3) set their pending bit on a rising input edge only. Level sources (4, 5) keep setting it while their input is high.
- R13: A programmable source is granted only if its own enable (enable word bit i) and the global enable (bit NUM_SRC) are both set. Priorities sit at bits 2i+1:2i of the priority word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NUM_SRC | Hardware request lines, one per programmable source |
| pf_in | input | 1 | Power-fail condition, level-sensitive |
| insn_end | input | 1 | Instruction-boundary evaluation strobe |
| reti | input | 1 | Return-from-interrupt pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 pending, 1 enables, 2 priorities |
| wr_data | input | 2*NUM_SRC | Write data |
| ack | output | 1 | Grant pulse |
| ack_vec | output | $clog2(NUM_SRC+1) | Granted source index |
| ack_lvl | output | 3 | Granted level |
| active_mask | output | 5 | In-service level mask |

## Verification
Arbitration is driven with sources spread across three programmed levels, so a pass shows that level beats index and that equal-level requests wait. Simultaneous requests at level 0 show the index order. The power-fail input is tested with the global enable off and then with its own enable off. Each half of that pair gates exactly one of the two paths. Software writes are placed against hardware edges and against boundary strobes in the same cycle, which separates the hardware-wins rule from the evaluation-abort rule. An edge source and a level source are each held high across repeated grants to show their different re-arming.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_NUM  = 5;
  localparam int LVL_W    = 3;
  localparam int PF_LEVEL = 4;

  typedef enum logic [1:0] {
    SEL_PEND   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_PRIO   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 6,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
  parameter logic [NUM_SRC-1:0] AUTO_CLR_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] hw_req_i,
  input  logic               sw_wr_i,
  input  logic [NUM_SRC-1:0] sw_data_i,
  input  logic [NUM_SRC-1:0] grant_1h_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] req_d_q;
  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] pend_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      assign hw_set[i] = hw_req_i[i] & ~req_d_q[i];
    end else begin : g_level
      assign hw_set[i] = hw_req_i[i];
    end
  end

  always_comb begin
    pend_d = pend_o & ~(grant_1h_i & AUTO_CLR_MASK);
    if (sw_wr_i) pend_d = sw_data_i;
    pend_d = pend_d | hw_set;   // hardware has the last word
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d_q <= '0;
      pend_o  <= '0;
    end else begin
      req_d_q <= hw_req_i;
      pend_o  <= pend_d;
    end
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((pend_o & $past(hw_set)) == $past(hw_set))); // R7
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0]   cand_i,
  input  logic [2*NUM_SRC-1:0] prio_i,
  input  logic                 pf_req_i,
  input  logic [LVL_NUM-1:0]   active_i,
  output logic                 win_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic [LVL_W-1:0]     win_lvl_o
);
  logic [LVL_W-1:0] lvl;

  always_comb begin
    win_o     = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    lvl       = '0;
    // walk from the highest index down so lower indices take ties
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      lvl = {1'b0, prio_i[2*i +: 2]};
      if (cand_i[i] && ((active_i >> lvl) == '0) &&
          (!win_o || lvl >= win_lvl_o)) begin
        win_o     = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl;
      end
    end
    if (pf_req_i && !active_i[PF_LEVEL]) begin
      win_o     = 1'b1;
      win_idx_o = IDX_W'(NUM_SRC);
      win_lvl_o = LVL_W'(PF_LEVEL);
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               push_i,
  input  logic [LVL_W-1:0]   push_lvl_i,
  input  logic               pop_i,
  output logic [LVL_NUM-1:0] mask_o
);
  logic [LVL_NUM-1:0] top_1h;
  logic [LVL_NUM-1:0] mask_d;

  always_comb begin
    top_1h = '0;
    for (int l = 0; l < LVL_NUM; l++) begin
      if (mask_o[l]) top_1h = LVL_NUM'(1) << l;
    end
    mask_d = mask_o;
    if (pop_i)  mask_d = mask_d & ~top_1h;
    if (push_i) mask_d = mask_d | (LVL_NUM'(1) << push_lvl_i);
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else     mask_o <= mask_d;
  end

  AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && mask_o != '0) |=>
      ($countones(mask_o) + 1 == $countones($past(mask_o)))); // R10
  AST_POP_KEEPS_LOWER: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> ((mask_o & ~$past(mask_o)) == '0)); // R10
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 6'b001111,
  parameter logic [NUM_SRC-1:0] AUTO_CLR_MASK = 6'b001111,
  localparam int DATA_W = 2 * NUM_SRC,
  localparam int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic               pf_in,
  input  logic               insn_end,
  input  logic               reti,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               ack,
  output logic [IDX_W-1:0]   ack_vec,
  output logic [LVL_W-1:0]   ack_lvl,
  output logic [LVL_NUM-1:0] active_mask
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] src_en_q;
  logic               gie_q;
  logic               pf_en_q;
  logic [DATA_W-1:0]  prio_q;
  logic               cfg_seen_q;
  logic               cfg_wr_now;
  logic               eval;
  logic               grant;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] grant_1h;
  logic               win;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;

  assign sel        = reg_sel_e'(wr_sel);
  assign cfg_wr_now = wr_en && (sel == SEL_ENABLE || sel == SEL_PRIO);
  assign eval       = insn_end && !cfg_seen_q && !cfg_wr_now;
  assign grant      = eval && win;
  assign cand       = pend & src_en_q & {NUM_SRC{gie_q}};

  always_comb begin
    grant_1h = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant && win_idx == IDX_W'(i)) grant_1h[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en_q   <= '0;
      gie_q      <= 1'b0;
      pf_en_q    <= 1'b0;
      prio_q     <= '0;
      cfg_seen_q <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_ENABLE) begin
        src_en_q <= wr_data[NUM_SRC-1:0];
        gie_q    <= wr_data[NUM_SRC];
        pf_en_q  <= wr_data[NUM_SRC+1];
      end
      if (wr_en && sel == SEL_PRIO) prio_q <= wr_data;
      if (insn_end)        cfg_seen_q <= 1'b0;
      else if (cfg_wr_now) cfg_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      ack_vec <= '0;
      ack_lvl <= '0;
    end else begin
      ack <= grant;
      if (grant) begin
        ack_vec <= win_idx;
        ack_lvl <= win_lvl;
      end
    end
  end

  irq_flag_bank #(
    .NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK), .AUTO_CLR_MASK(AUTO_CLR_MASK)
  ) flags_i (
    .clk(clk), .rst(rst), .hw_req_i(hw_req),
    .sw_wr_i(wr_en && sel == SEL_PEND), .sw_data_i(wr_data[NUM_SRC-1:0]),
    .grant_1h_i(grant_1h), .pend_o(pend)
  );

  irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) pick_i (
    .cand_i(cand), .prio_i(prio_q), .pf_req_i(pf_in && pf_en_q),
    .active_i(active_mask), .win_o(win), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  irq_level_stack stack_i (
    .clk(clk), .rst(rst), .push_i(grant), .push_lvl_i(win_lvl),
    .pop_i(reti), .mask_o(active_mask)
  );

  AST_GRANT_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ack |-> (($past(active_mask) >> ack_lvl) == '0)); // R3
  AST_GRANT_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ack |-> active_mask[ack_lvl]); // R3
  AST_NO_EVAL_ON_CFG: assert property (@(posedge clk) disable iff (rst)
    ack |-> ($past(insn_end) && !$past(cfg_wr_now) && !$past(cfg_seen_q))); // R8
  AST_TOP_LEVEL_PF_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_lvl == LVL_W'(PF_LEVEL)) |-> (ack_vec == IDX_W'(NUM_SRC))); // R2
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !insn_end |=> !ack); // R11
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] hw_req = '0;
  logic pf_in = 1'b0, insn_end = 1'b0, reti = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [2*NS-1:0] wr_data = '0;
  logic ack;
  logic [2:0] ack_vec, ack_lvl;
  logic [4:0] active_mask;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst(rst), .hw_req(hw_req), .pf_in(pf_in), .insn_end(insn_end),
    .reti(reti), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack(ack), .ack_vec(ack_vec), .ack_lvl(ack_lvl), .active_mask(active_mask)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hw_req = '0; pf_in = 1'b0; insn_end = 1'b0; reti = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(logic [1:0] s, logic [2*NS-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [2*NS-1:0] en_word(logic [NS-1:0] src, bit g, bit pf);
    return {4'b0, pf, g, src};
  endfunction

  task automatic boundary();
    insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic exp_ack(string req, int vec, int lvl);
    boundary();
    chk({req, " ack"}, ack, 1);
    chk({req, " vec"}, ack_vec, vec);
    chk({req, " lvl"}, ack_lvl, lvl);
  endtask

  task automatic exp_none(string req);
    boundary();
    chk({req, " no ack"}, ack, 0);
  endtask

  task automatic setup(logic [2*NS-1:0] en, logic [2*NS-1:0] pr);
    wr(2'd1, en);
    wr(2'd2, pr);
    exp_none("R8 dummy boundary after config");
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mask after reset", active_mask, 0);
    chk("R1 ack after reset", ack, 0);
    wr(2'd1, en_word(6'h3F, 1, 0));
    exp_none("R8 suppressed after enable write");
    wr(2'd0, 12'h00A);                 // R5 software sets sources 1 and 3
    exp_ack("R4 R1 default level, lowest index", 1, 0);
    chk("R1 mask level0", active_mask, 5'b00001);
    @(negedge clk);
    chk("R11 ack lasts one cycle", ack, 0);
  endtask

  task automatic t_nesting();
    do_reset();
    setup(en_word(6'h3F, 1, 0), 12'h052); // src0=2, src2=1, src3=1
    wr(2'd0, 12'h008);
    exp_ack("R5 R13 src3 level1", 3, 1);
    chk("R3 mask", active_mask, 5'b00010);
    wr(2'd0, 12'h002);
    exp_none("R3 lower level waits");
    wr(2'd0, 12'h003);
    exp_ack("R3 higher preempts", 0, 2);
    chk("R3 nested mask", active_mask, 5'b00110);
    wr(2'd0, 12'h006);
    exp_none("R3 below active waits");
    do_reti();
    chk("R10 pops highest", active_mask, 5'b00010);
    exp_none("R3 equal level waits");
    do_reti();
    chk("R10 empty", active_mask, 0);
    exp_ack("R3 level1 before level0", 2, 1);
    do_reti();
    exp_ack("R4 remaining level0", 1, 0);
    do_reti();
    exp_none("R9 auto-cleared flags");
  endtask

  task automatic t_pf();
    do_reset();
    setup(en_word(6'h3F, 0, 1), 12'h000);
    pf_in = 1'b1;
    wr(2'd0, 12'h001);
    exp_ack("R2 pf ignores global enable", 6, 4);
    chk("R2 mask", active_mask, 5'b10000);
    exp_none("R3 pf cannot nest itself");
    do_reti();
    exp_ack("R2 pf level-sensitive", 6, 4);
    pf_in = 1'b0;
    do_reti();
    exp_none("R13 global enable off");
    setup(en_word(6'h3F, 1, 0), 12'h000);
    pf_in = 1'b1;
    exp_ack("R2 pf disabled, src0 wins", 0, 0);
    pf_in = 1'b0;
  endtask

  task automatic t_cfg_abort();
    do_reset();
    wr(2'd0, 12'h004);
    wr(2'd1, en_word(6'h3F, 1, 0));
    exp_none("R8 strobe after enable write");
    exp_ack("R8 next strobe evaluates", 2, 0);
    do_reti();
    wr(2'd0, 12'h008);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 12'h0C0; insn_end = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; insn_end = 1'b0;
    chk("R8 same-cycle write aborts", ack, 0);
    exp_ack("R8 new priority used", 3, 3);
    do_reti();
    wr(2'd1, en_word(6'h3E, 1, 0));
    exp_none("R8 dummy");
    wr(2'd0, 12'h001);
    exp_none("R13 source enable off");
  endtask

  task automatic t_withdraw();
    do_reset();
    setup(en_word(6'h3F, 1, 0), 12'h000);
    wr(2'd0, 12'h002);
    wr(2'd0, 12'h000);
    exp_none("R6 withdrawn before grant");
    wr(2'd0, 12'h010);
    exp_ack("R6 src4 granted", 4, 0);
    wr(2'd0, 12'h000);
    chk("R6 clear after grant keeps mask", active_mask, 5'b00001);
    do_reti();
    exp_none("R6 cleared flag stays clear");
  endtask

  task automatic t_hw();
    do_reset();
    setup(en_word(6'h3F, 1, 0), 12'h000);
    hw_req[2] = 1'b1;
    wr(2'd0, 12'h000);                 // same cycle as the rising edge
    exp_ack("R7 hardware set wins", 2, 0);
    do_reti();
    exp_none("R12 edge source no re-arm while high");
    hw_req[2] = 1'b0;
    hw_req[5] = 1'b1;
    @(negedge clk);
    exp_ack("R12 level source", 5, 0);
    do_reti();
    wr(2'd0, 12'h000);
    exp_ack("R12 level re-sets while high", 5, 0);
    hw_req[5] = 1'b0;
    do_reti();
    exp_ack("R9 kept flag serviced again", 5, 0);
    do_reti();
    wr(2'd0, 12'h000);
    exp_none("R9 software clear ends it");
  endtask

  initial begin
    t_reset();
    t_nesting();
    t_pf();
    t_cfg_abort();
    t_withdraw();
    t_hw();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule